// File: doc/BRIEF.md
# Transceiver Power-Up Reset Sequencer

This controller brings a USB device core out of reset in a safe order. Once its own reset is released and its clock runs, it waits for a start pulse. The first step turns on the transceiver bias by dropping the power-down output. The core is then held in forced reset for a programmable number of settling cycles, because the transceiver's behaviour is undefined during that window.

When the wait has fully elapsed, the block releases the forced reset. One cycle later it fires a single-cycle strobe that clears any stale interrupt flags. After that it raises a ready flag, which stays high.

The settling count is sampled once, at the start. A count below the parameter `MIN_WAIT` (default 1) is raised to `MIN_WAIT`, so with the defaults a count of zero gives one cycle. A start pulse while the sequence is running has no effect. A start pulse while ready re-runs the sequence: the bias stays on and the forced reset is asserted again.

Top module: `usb_pwrup_seq`

## Requirements
- R1: While `rst_n` is low, and afterwards until the first start pulse, `pwr_down_o`=1, `core_rst_o`=1, `irq_clr_o`=0 and `ready_o`=0.
- R2: A start pulse sampled while idle drops `pwr_down_o` to 0 in the cycle after that edge, while `core_rst_o` stays 1.
- R3: `core_rst_o` stays 1 with `pwr_down_o`=0 for exactly W cycles. W = max(N, MIN_WAIT), where N is `startup_cycles_i` sampled at the start edge, so with the defaults N=0 gives W=1.
- R4: In the cycle after the wait, `core_rst_o` is 0 while `irq_clr_o` and `ready_o` are both still 0.
- R5: In the next cycle `irq_clr_o` is 1 for exactly one cycle, with `core_rst_o` already 0.
- R6: `ready_o` becomes 1 in the cycle after the clear strobe. It then stays 1, with `core_rst_o`=0 and `pwr_down_o`=0, until a restart or a reset.
- R7: Start pulses and changes to `startup_cycles_i` that arrive after the start edge and before ready have no effect on the outputs or on the wait length.
- R8: A start pulse sampled while ready drops `ready_o` and sets `core_rst_o` to 1 in the next cycle, with `pwr_down_o` kept at 0. It then runs a new wait, sampled as in R3, followed by the release, clear and ready steps.
- R9: Driving `rst_n` low at any point returns all outputs to the R1 values at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| start_i | input | 1 | Start request, sampled at the clock edge |
| startup_cycles_i | input | CNT_W | Transceiver settling time in clock cycles |
| pwr_down_o | output | 1 | 1 keeps the transceiver bias switched off |
| core_rst_o | output | 1 | 1 holds the device core in forced reset |
| irq_clr_o | output | 1 | Single-cycle strobe that clears pending interrupt flags |
| ready_o | output | 1 | Core released and interrupts flushed |

## Verification
All outputs decode one state register. Each result is therefore due exactly one edge after the edge that causes it:
- the power-up shows one cycle after the start edge;
- the reset release shows W cycles after that;
- the clear strobe shows one cycle after the release;
- the ready flag shows one cycle after the strobe.

The bench drives inputs on the falling edge and checks every output on each later falling edge, counting the expected cycle from the settling count it drove. This lets a wait that is one cycle short or one cycle long show up as a mismatch. Reset is asynchronous, so its effect is checked one time unit after `rst_n` falls.

// File: rtl/usb_pwrup_pkg.sv
package usb_pwrup_pkg;
   typedef enum logic [2:0] {
      ST_OFF      = 3'd0,
      ST_POWERING = 3'd1,
      ST_RELEASE  = 3'd2,
      ST_CLEAR    = 3'd3,
      ST_READY    = 3'd4
   } seq_state_t;

   typedef struct packed {
      logic pwr_down;
      logic core_rst;
      logic irq_clr;
      logic ready;
   } seq_out_t;
endpackage

// File: rtl/usb_pwrup_wait_cnt.sv
module usb_pwrup_wait_cnt #(
   parameter int CNT_W    = 16,
   parameter int MIN_WAIT = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             dec_i,
   input  logic [CNT_W-1:0] cycles_i,
   output logic             done_o
);
   localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_WAIT);

   logic [CNT_W-1:0] remain_q;
   logic [CNT_W-1:0] eff_wait;

   generate
      if (MIN_WAIT < 1) begin : g_bad_min
         $error("MIN_WAIT must be at least 1");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_w
         $error("CNT_W must be within 1..32");
      end
   endgenerate

   // effective wait is never below the floor; the counter holds wait-1
   always_comb begin
      eff_wait = (cycles_i < FLOOR) ? FLOOR : cycles_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
      end else if (load_i) begin
         remain_q <= eff_wait - CNT_W'(1);
      end else if (dec_i && remain_q != '0) begin
         remain_q <= remain_q - CNT_W'(1);
      end
   end

   assign done_o = (remain_q == '0);
endmodule

// File: rtl/usb_pwrup_fsm.sv
module usb_pwrup_fsm
   import usb_pwrup_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       wait_done_i,
   output logic       load_o,
   output logic       dec_o,
   output seq_state_t state_o
);
   seq_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      load_o  = 1'b0;
      dec_o   = 1'b0;
      unique case (state_q)
         ST_OFF: if (start_i) begin
            state_d = ST_POWERING;
            load_o  = 1'b1;
         end
         ST_POWERING: begin
            dec_o = 1'b1;
            if (wait_done_i) state_d = ST_RELEASE;
         end
         ST_RELEASE: state_d = ST_CLEAR;
         ST_CLEAR:   state_d = ST_READY;
         ST_READY: if (start_i) begin
            state_d = ST_POWERING;
            load_o  = 1'b1;
         end
         default: state_d = ST_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_OFF;
      else        state_q <= state_d;
   end

   assign state_o = state_q;
endmodule

// File: rtl/usb_pwrup_out_dec.sv
module usb_pwrup_out_dec
   import usb_pwrup_pkg::*;
(
   input  seq_state_t state_i,
   output seq_out_t   out_o
);
   always_comb begin
      out_o = '{pwr_down: 1'b1, core_rst: 1'b1, irq_clr: 1'b0, ready: 1'b0};
      unique case (state_i)
         ST_OFF:      ;
         ST_POWERING: out_o.pwr_down = 1'b0;
         ST_RELEASE:  out_o = '{pwr_down: 1'b0, core_rst: 1'b0, irq_clr: 1'b0, ready: 1'b0};
         ST_CLEAR:    out_o = '{pwr_down: 1'b0, core_rst: 1'b0, irq_clr: 1'b1, ready: 1'b0};
         ST_READY:    out_o = '{pwr_down: 1'b0, core_rst: 1'b0, irq_clr: 1'b0, ready: 1'b1};
         default:     ;
      endcase
   end
endmodule

// File: rtl/usb_pwrup_seq.sv
module usb_pwrup_seq
   import usb_pwrup_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int MIN_WAIT = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] startup_cycles_i,
   output logic             pwr_down_o,
   output logic             core_rst_o,
   output logic             irq_clr_o,
   output logic             ready_o
);
   logic       load, dec, done;
   seq_state_t state;
   seq_out_t   outs;

   usb_pwrup_wait_cnt #(.CNT_W(CNT_W), .MIN_WAIT(MIN_WAIT)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load_i(load), .dec_i(dec),
      .cycles_i(startup_cycles_i), .done_o(done)
   );

   usb_pwrup_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .wait_done_i(done),
      .load_o(load), .dec_o(dec), .state_o(state)
   );

   usb_pwrup_out_dec u_dec (.state_i(state), .out_o(outs));

   assign pwr_down_o = outs.pwr_down;
   assign core_rst_o = outs.core_rst;
   assign irq_clr_o  = outs.irq_clr;
   assign ready_o    = outs.ready;
endmodule

// File: rtl/usb_pwrup_seq_chk.sv
module usb_pwrup_seq_chk #(
   parameter int CNT_W    = 16,
   parameter int MIN_WAIT = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [CNT_W-1:0] startup_cycles_i,
   input logic             pwr_down_o,
   input logic             core_rst_o,
   input logic             irq_clr_o,
   input logic             ready_o
);
   logic [CNT_W-1:0] cap_q;
   logic [CNT_W:0]   held_q;
   logic [CNT_W:0]   exp_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q  <= '0;
         held_q <= '0;
      end else if (start_i && (pwr_down_o || ready_o)) begin
         cap_q  <= startup_cycles_i;
         held_q <= '0;
      end else if (core_rst_o && !pwr_down_o) begin
         held_q <= held_q + 1'b1;
      end
   end

   always_comb begin
      exp_w = ({1'b0, cap_q} < (CNT_W+1)'(MIN_WAIT)) ? (CNT_W+1)'(MIN_WAIT) : {1'b0, cap_q};
   end

   assert_wait_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_rst_o) |-> held_q == exp_w);
   assert_release_powered_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_rst_o) |-> !pwr_down_o && !irq_clr_o && !ready_o);
   assert_clear_after_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr_o |-> !core_rst_o && $past(!core_rst_o) && !$past(irq_clr_o));
   assert_clear_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr_o |=> !irq_clr_o);
   assert_ready_after_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_o) |-> $past(irq_clr_o));
   assert_ready_outputs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> !core_rst_o && !pwr_down_o);
   assert_bias_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_down_o && $past(pwr_down_o) |-> core_rst_o);
   assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_clr_o, ready_o, core_rst_o}));
endmodule

bind usb_pwrup_seq usb_pwrup_seq_chk #(.CNT_W(CNT_W), .MIN_WAIT(MIN_WAIT)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .startup_cycles_i(startup_cycles_i),
   .pwr_down_o(pwr_down_o), .core_rst_o(core_rst_o),
   .irq_clr_o(irq_clr_o), .ready_o(ready_o)
);

// File: tb/tb_usb_pwrup_seq.sv
`timescale 1ns/1ps
module tb_usb_pwrup_seq;
   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [CNT_W-1:0] startup_cycles_i = '0;
   logic             pwr_down_o, core_rst_o, irq_clr_o, ready_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit finished = 1'b0;

   usb_pwrup_seq #(.CNT_W(CNT_W), .MIN_WAIT(1)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .startup_cycles_i(startup_cycles_i),
      .pwr_down_o(pwr_down_o), .core_rst_o(core_rst_o),
      .irq_clr_o(irq_clr_o), .ready_o(ready_o)
   );

   always #2 clk = ~clk;

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000 && !finished) begin
         finished = 1'b1;
         errors++;
         $display("FAIL watchdog: actual running expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   function automatic int exp_wait(input int n);
      return (n < 1) ? 1 : n;
   endfunction

   // expected vector order: {pwr_down, core_rst, irq_clr, ready}
   task automatic chk(input string req, input logic [3:0] exp);
      logic [3:0] act;
      act = {pwr_down_o, core_rst_o, irq_clr_o, ready_o};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic run_seq(input int n, input bit noise, input bit restart);
      int w;
      w = exp_wait(n);
      @(negedge clk);
      start_i = 1'b1;
      startup_cycles_i = CNT_W'(n);
      @(negedge clk);
      start_i = 1'b0;
      if (restart) chk("R8", 4'b0100);
      else         chk("R2", 4'b0100);
      for (int i = 1; i < w; i++) begin
         if (noise) begin
            start_i = 1'($urandom_range(0, 1));
            startup_cycles_i = CNT_W'($urandom_range(0, 60));
         end
         @(negedge clk);
         chk(noise ? "R7" : "R3", 4'b0100);
      end
      if (noise) start_i = 1'b1;
      @(negedge clk);
      chk("R4", 4'b0000);
      @(negedge clk);
      start_i = 1'b0;
      chk("R5", 4'b0010);
      @(negedge clk);
      chk("R6", 4'b0001);
      @(negedge clk);
      chk("R6", 4'b0001);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk("R1", 4'b1100);
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk("R1", 4'b1100);
      end
      run_seq(0, 1'b0, 1'b0);
      run_seq(1, 1'b0, 1'b1);
      run_seq(2, 1'b0, 1'b1);
      run_seq(5, 1'b1, 1'b1);
      for (int k = 0; k < 25; k++) begin
         run_seq($urandom_range(0, 40), 1'b1, 1'b1);
      end
      run_seq(1000, 1'b0, 1'b1);
      // R9: reset in the middle of a wait
      @(negedge clk);
      start_i = 1'b1;
      startup_cycles_i = CNT_W'(10);
      @(negedge clk);
      start_i = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R9", 4'b1100);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9", 4'b1100);
      run_seq(3, 1'b0, 1'b0);
      rst_n = 1'b0;
      #1;
      chk("R9", 4'b1100);
      @(negedge clk);
      rst_n = 1'b1;
      run_seq(0, 1'b1, 1'b0);
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule